// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block collects interrupt lines from peripherals, keeps per-interrupt enable, trigger mode and CPU routing state, and raises one request line per CPU interface. Shared lines (IDs 32 and up) are routed through a per-interrupt CPU target mask. IDs 0-31 are private to each CPU: IDs 0-15 are software interrupts raised through a fan-out register, and IDs 16-31 come from a per-CPU bank of private inputs. Each private line `ppi_i[c*16+i]` is ID 16+i of CPU c.

Software reaches the state through a 32-bit word-addressed register port. Every access carries the index of the CPU that makes it, and that index selects the banked private state. Reads are combinational in the cycle of the request. A write takes effect at the clock edge that samples it. A CPU interface tells the block that it has taken an interrupt by pulsing `ack_i` with its own index and the interrupt ID. For edge-type interrupts this clears the pending state. `NUM_IRQ` is a multiple of 32, from 64 to 1024. `NUM_CPU` ranges from 1 to 8.

Word map: control at 0x000 (bit 0 = distributor enable), type at 0x001, software interrupt at 0x002, enable-set at 0x020+k, enable-clear at 0x040+k, configuration at 0x080+k, targets at 0x100+k.

Top module: `irq_dist`

## Requirements
- R1: After reset, the control word, all enable bits, all shared target masks and the configuration of every ID from 16 up read zero, and `irq_o` is all low.
- R2: The type word at 0x001 returns NUM_IRQ/32-1 in bits [4:0] and zero above. Writes to it change nothing.
- R3: The enable of ID n is bit n%32 of set word 0x020+n/32 and of clear word 0x040+n/32. Writing 1 sets the enable (set word) or clears it (clear word). Writing 0 has no effect. Both words read the current enables.
- R4: Enable word 0 (IDs 0-31) is banked: each `cpu_i` reads and changes only its own copy.
- R5: Target word 0x100+n/4 holds the target mask of ID n in byte lane n%4 (bit c = CPU c). Bits for CPUs at or above NUM_CPU are dropped on write and read zero.
- R6: Target words 0x100-0x107 (IDs 0-31) are read-only. Every byte reads as the one-hot bit of the accessing CPU.
- R7: Configuration word 0x080+n/16 holds ID n in bits [2*(n%16)+1:2*(n%16)]. The upper bit is 1 for rising edge and 0 for level high. The lower bit reads zero. IDs 0-15 always read 2'b10, and writes to them are ignored.
- R8: A write to 0x002 makes ID wdata[3:0] pending for every CPU c whose bit is set in wdata[23:16] (c < NUM_CPU). An acknowledge of that ID by CPU c clears the pending state for that CPU only. The word reads zero.
- R9: `irq_o[c]` is high while the distributor is enabled and an enabled pending interrupt reaches CPU c. A shared ID reaches CPU c when bit c of its target mask is set. A private ID reaches only its owning CPU. A level interrupt is pending while its line is high.
- R10: With control bit 0 clear, `irq_o` is all zero. A level line that is still high is delivered once the distributor is enabled again. Rising edges seen while it is disabled are not latched.
- R11: An edge interrupt latches on a rising edge, stays pending after the line falls, and clears on acknowledge. For a shared ID the acknowledge may come from any CPU; for a private ID only from its owner. An acknowledge of a level interrupt whose line is high leaves it pending.
- R12: Unimplemented word addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 9 | Word address |
| cpu_i | input | CPU_W | Index of the accessing CPU |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| spi_i | input | NUM_IRQ-32 | Shared lines; bit j is ID j+32 |
| ppi_i | input | NUM_CPU*16 | Private lines; bit c*16+i is ID 16+i of CPU c |
| ack_i | input | 1 | Acknowledge strobe |
| ack_cpu_i | input | CPU_W | CPU that acknowledges |
| ack_id_i | input | ID_W | Acknowledged interrupt ID |
| irq_o | output | NUM_CPU | Request line per CPU interface |

## Verification
The bench targets the banked corner cases. The banked enable word is checked per CPU: a design that shares it would let one CPU unmask another's software interrupt. The read-only private target words are checked: a design that stores them would return the written value instead of the caller's one-hot bit. Target bits above NUM_CPU are checked: leaking them would show nonzero upper nibbles. The disable window is exercised with both trigger modes. A design that latches edges while disabled would raise a request after re-enable. A design that drops level state would fail to raise one. The bench also checks that an acknowledge clears an edge interrupt but not a held level line, and that a software interrupt reaches only the listed and enabled CPUs.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int unsigned AW = 9;
  localparam logic [AW-1:0] A_CTRL  = 9'h000;
  localparam logic [AW-1:0] A_TYPE  = 9'h001;
  localparam logic [AW-1:0] A_SWI   = 9'h002;
  localparam logic [AW-1:0] A_ENSET = 9'h020;
  localparam logic [AW-1:0] A_ENCLR = 9'h040;
  localparam logic [AW-1:0] A_CFG   = 9'h080;
  localparam logic [AW-1:0] A_TARG  = 9'h100;
  localparam int unsigned PRIV_IDS = 32;
  localparam int unsigned SWI_IDS  = 16;
endpackage

// File: rtl/irq_dist_bank.sv
module irq_dist_bank (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        dist_en_i,
  input  logic [31:0] en_set_i,
  input  logic [31:0] en_clr_i,
  input  logic [15:0] sgi_set_i,
  input  logic [15:0] ppi_i,
  input  logic [15:0] ppi_edge_i,
  input  logic        ack_i,
  input  logic [4:0]  ack_id_i,
  output logic [31:0] en_o,
  output logic        req_o
);
  logic [31:0] en_q, ack_m;
  logic [15:0] sgi_q, ppi_q, lat_q, ppi_pend;

  assign ack_m = ack_i ? (32'd1 << ack_id_i) : 32'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      sgi_q <= '0;
      ppi_q <= '0;
      lat_q <= '0;
    end else begin
      en_q  <= (en_q | en_set_i) & ~en_clr_i;
      sgi_q <= (sgi_q & ~ack_m[15:0]) | sgi_set_i;
      ppi_q <= ppi_i;
      // edges seen while disabled are dropped
      lat_q <= ppi_edge_i & ((ppi_i & ~ppi_q & {16{dist_en_i}}) | (lat_q & ~ack_m[31:16]));
    end
  end

  assign ppi_pend = (ppi_edge_i & lat_q) | (~ppi_edge_i & ppi_i);
  assign en_o  = en_q;
  assign req_o = dist_en_i & (|({ppi_pend, sgi_q} & en_q));

  a_r8_swi_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_id_i < 5'd16 && sgi_set_i == '0)
      |=> ((sgi_q & $past(16'd1 << ack_id_i[3:0])) == '0));

  a_r4_en_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|en_set_i) |=> ((en_o & $past(en_set_i & ~en_clr_i)) == $past(en_set_i & ~en_clr_i)));
endmodule

// File: rtl/irq_dist_line.sv
module irq_dist_line #(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dist_en_i,
  input  logic               line_i,
  input  logic               en_set_i,
  input  logic               en_clr_i,
  input  logic               targ_we_i,
  input  logic [NUM_CPU-1:0] targ_i,
  input  logic               cfg_we_i,
  input  logic               cfg_edge_i,
  input  logic               ack_i,
  output logic               en_o,
  output logic               edge_o,
  output logic [NUM_CPU-1:0] targ_o,
  output logic [NUM_CPU-1:0] req_o
);
  logic en_q, edge_q, line_q, lat_q, pend;
  logic [NUM_CPU-1:0] targ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      edge_q <= 1'b0;
      line_q <= 1'b0;
      lat_q  <= 1'b0;
      targ_q <= '0;
    end else begin
      en_q   <= (en_q | en_set_i) & ~en_clr_i;
      line_q <= line_i;
      lat_q  <= edge_q & ((line_i & ~line_q & dist_en_i) | (lat_q & ~ack_i));
      if (cfg_we_i)  edge_q <= cfg_edge_i;
      if (targ_we_i) targ_q <= targ_i;
    end
  end

  assign pend   = edge_q ? lat_q : line_i;
  assign req_o  = {NUM_CPU{dist_en_i & en_q & pend}} & targ_q;
  assign en_o   = en_q;
  assign edge_o = edge_q;
  assign targ_o = targ_q;

  a_r3_clr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_i |=> !en_o);

  a_r11_latch_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lat_q) |-> $past(dist_en_i && line_i));

  a_r11_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && edge_q && !ack_i && !cfg_we_i) |=> lat_q);
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 4,
  localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned ID_W   = $clog2(NUM_IRQ)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [CPU_W-1:0]        cpu_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [NUM_IRQ-33:0]     spi_i,
  input  logic [NUM_CPU*16-1:0]   ppi_i,
  input  logic                    ack_i,
  input  logic [CPU_W-1:0]        ack_cpu_i,
  input  logic [ID_W-1:0]         ack_id_i,
  output logic [NUM_CPU-1:0]      irq_o
);
  localparam int unsigned NUM_SH    = NUM_IRQ - PRIV_IDS;
  localparam int unsigned EN_WORDS  = NUM_IRQ / 32;
  localparam int unsigned CFG_WORDS = NUM_IRQ / 16;
  localparam int unsigned TG_WORDS  = NUM_IRQ / 4;
  localparam int unsigned CTRL_B  = 32'(A_CTRL);
  localparam int unsigned TYPE_B  = 32'(A_TYPE);
  localparam int unsigned SWI_B   = 32'(A_SWI);
  localparam int unsigned ENSET_B = 32'(A_ENSET);
  localparam int unsigned ENCLR_B = 32'(A_ENCLR);
  localparam int unsigned CFG_B   = 32'(A_CFG);
  localparam int unsigned TARG_B  = 32'(A_TARG);

  logic              wr, rd, dist_en_q;
  int unsigned       a_w;
  logic [15:0]       cfg_pp_q;
  logic [31:0]       bank_en [NUM_CPU];
  logic [NUM_CPU-1:0] bank_req;
  logic [NUM_SH-1:0]  sh_en, sh_edge;
  logic [NUM_CPU-1:0] sh_targ [NUM_SH];
  logic [NUM_CPU-1:0] line_req [NUM_SH];
  logic [2*NUM_IRQ-1:0] cfg_full;
  logic [8*NUM_SH-1:0]  targ_full;

  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;
  assign a_w = 32'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dist_en_q <= 1'b0;
      cfg_pp_q  <= '0;
    end else if (wr) begin
      if (a_w == CTRL_B) dist_en_q <= wdata_i[0];
      if (a_w == CFG_B + 1) begin
        for (int i = 0; i < 16; i++) cfg_pp_q[i] <= wdata_i[2*i+1];
      end
    end
  end

  // private banks, one per CPU interface
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    logic        sel, ack_c;
    logic [31:0] set_m, clr_m;
    logic [15:0] sgi_m;
    assign sel   = (cpu_i == CPU_W'(c));
    assign set_m = (wr && sel && a_w == ENSET_B) ? wdata_i : 32'd0;
    assign clr_m = (wr && sel && a_w == ENCLR_B) ? wdata_i : 32'd0;
    assign sgi_m = (wr && a_w == SWI_B && wdata_i[16+c]) ? (16'd1 << wdata_i[3:0]) : 16'd0;
    assign ack_c = ack_i && ack_cpu_i == CPU_W'(c) && ack_id_i < ID_W'(PRIV_IDS);
    irq_dist_bank u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .dist_en_i  (dist_en_q),
      .en_set_i   (set_m),
      .en_clr_i   (clr_m),
      .sgi_set_i  (sgi_m),
      .ppi_i      (ppi_i[c*16 +: 16]),
      .ppi_edge_i (cfg_pp_q),
      .ack_i      (ack_c),
      .ack_id_i   (ack_id_i[4:0]),
      .en_o       (bank_en[c]),
      .req_o      (bank_req[c])
    );
  end

  // shared lines, one slice per interrupt ID
  for (genvar j = 0; j < NUM_SH; j++) begin : g_line
    localparam int unsigned ID = j + PRIV_IDS;
    irq_dist_line #(.NUM_CPU(NUM_CPU)) u_line (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .dist_en_i  (dist_en_q),
      .line_i     (spi_i[j]),
      .en_set_i   (wr && a_w == ENSET_B + ID/32 && wdata_i[ID%32]),
      .en_clr_i   (wr && a_w == ENCLR_B + ID/32 && wdata_i[ID%32]),
      .targ_we_i  (wr && a_w == TARG_B + ID/4),
      .targ_i     (wdata_i[8*(ID%4) +: NUM_CPU]),
      .cfg_we_i   (wr && a_w == CFG_B + ID/16),
      .cfg_edge_i (wdata_i[2*(ID%16)+1]),
      .ack_i      (ack_i && ack_id_i == ID_W'(ID)),
      .en_o       (sh_en[j]),
      .edge_o     (sh_edge[j]),
      .targ_o     (sh_targ[j]),
      .req_o      (line_req[j])
    );
  end

  always_comb begin
    logic [NUM_CPU-1:0] acc;
    acc = '0;
    for (int j = 0; j < NUM_SH; j++) acc = acc | line_req[j];
    irq_o = acc | bank_req;
  end

  always_comb begin
    cfg_full  = '0;
    targ_full = '0;
    for (int i = 0; i < 16; i++) cfg_full[2*i +: 2] = 2'b10;
    for (int i = 0; i < 16; i++) cfg_full[2*(i+16) +: 2] = {cfg_pp_q[i], 1'b0};
    for (int j = 0; j < NUM_SH; j++) begin
      cfg_full[2*(j+PRIV_IDS) +: 2] = {sh_edge[j], 1'b0};
      targ_full[8*j +: 8] = 8'(sh_targ[j]);
    end
  end

  always_comb begin
    logic [31:0] own_en;
    logic [7:0]  own_b;
    int unsigned k;
    own_en = '0;
    for (int c = 0; c < NUM_CPU; c++) if (cpu_i == CPU_W'(c)) own_en = bank_en[c];
    own_b   = 8'd1 << cpu_i;
    k       = 0;
    rdata_o = '0;
    if (rd) begin
      if (a_w == CTRL_B) begin
        rdata_o = {31'd0, dist_en_q};
      end else if (a_w == TYPE_B) begin
        rdata_o = 32'(EN_WORDS - 1);
      end else if ((a_w >= ENSET_B && a_w < ENSET_B + EN_WORDS) ||
                   (a_w >= ENCLR_B && a_w < ENCLR_B + EN_WORDS)) begin
        k = (a_w >= ENCLR_B) ? a_w - ENCLR_B : a_w - ENSET_B;
        rdata_o = (k == 0) ? own_en : 32'(sh_en[(k-1)*32 +: 32]);
      end else if (a_w >= CFG_B && a_w < CFG_B + CFG_WORDS) begin
        k = a_w - CFG_B;
        rdata_o = cfg_full[k*32 +: 32];
      end else if (a_w >= TARG_B && a_w < TARG_B + TG_WORDS) begin
        k = a_w - TARG_B;
        rdata_o = (k < 8) ? {4{own_b}} : targ_full[(k-8)*32 +: 32];
      end
    end
  end

  a_r10_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dist_en_q |-> (irq_o == '0));

  a_r4_cpu_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (32'(cpu_i) < NUM_CPU));
endmodule

// File: tb/irq_dist_test.sv
module irq_dist_test;
  localparam int unsigned NUM_IRQ = 64;
  localparam int unsigned NUM_CPU = 4;

  logic        clk, rst_n, req, we, ack;
  logic [8:0]  addr;
  logic [1:0]  cpu, ack_cpu;
  logic [5:0]  ack_id;
  logic [31:0] wdata, rdata, r;
  logic [31:0] spi;
  logic [63:0] ppi;
  logic [3:0]  irq;
  int total = 0, bad = 0;
  bit done = 0;

  irq_dist #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .cpu_i(cpu), .wdata_i(wdata), .rdata_o(rdata), .spi_i(spi), .ppi_i(ppi),
    .ack_i(ack), .ack_cpu_i(ack_cpu), .ack_id_i(ack_id), .irq_o(irq));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [8:0]  wa; logic [1:0] wc; logic [31:0] wd;
    logic [8:0]  ra; logic [1:0] rc; logic [31:0] ex;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{9'h021, 2'd0, 32'h000000F0, 9'h021, 2'd0, 32'h000000F0}, // R3 set
    '{9'h041, 2'd0, 32'h00000030, 9'h021, 2'd0, 32'h000000C0}, // R3 clear
    '{9'h021, 2'd0, 32'h00000000, 9'h041, 2'd0, 32'h000000C0}, // R3 zero no effect
    '{9'h020, 2'd1, 32'h00000101, 9'h020, 2'd1, 32'h00000101}, // R4 own bank
    '{9'h020, 2'd0, 32'h00000000, 9'h020, 2'd0, 32'h00000000}, // R4 other bank
    '{9'h108, 2'd0, 32'hFF0F0301, 9'h108, 2'd0, 32'h0F0F0301}, // R5 lanes
    '{9'h101, 2'd2, 32'hFFFFFFFF, 9'h101, 2'd2, 32'h04040404}, // R6 read-only
    '{9'h100, 2'd0, 32'h00000000, 9'h100, 2'd3, 32'h08080808}, // R6 cpu3
    '{9'h082, 2'd0, 32'hFFFFFFFF, 9'h082, 2'd0, 32'hAAAAAAAA}, // R7 shared
    '{9'h080, 2'd0, 32'h00000000, 9'h080, 2'd0, 32'hAAAAAAAA}, // R7 fixed
    '{9'h081, 2'd0, 32'h55555555, 9'h081, 2'd0, 32'h00000000}, // R7 low bits
    '{9'h003, 2'd0, 32'hFFFFFFFF, 9'h003, 2'd0, 32'h00000000}  // R12 hole
  };

  function automatic string vtag(int i);
    case (i)
      0, 1, 2: return "R3";
      3, 4:    return "R4";
      5:       return "R5";
      6, 7:    return "R6";
      8, 9, 10: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [1:0] c, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; cpu = c; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [1:0] c, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; cpu = c;
    #2 d = rdata;
    req = 1'b0;
  endtask

  task automatic do_ack(input logic [1:0] c, input logic [5:0] id);
    @(negedge clk);
    ack = 1'b1; ack_cpu = c; ack_id = id;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic set_spi(input int i, input logic v);
    @(negedge clk);
    spi[i] = v;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; ack = 1'b0; addr = '0; cpu = '0;
    ack_cpu = '0; ack_id = '0; wdata = '0; spi = '0; ppi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #2 chk("R1", 32'(irq), 32'h0);
    rd(9'h000, 2'd0, r); chk("R1", r, 32'h0);
    rd(9'h021, 2'd0, r); chk("R1", r, 32'h0);
    rd(9'h108, 2'd0, r); chk("R1", r, 32'h0);
    rd(9'h082, 2'd0, r); chk("R1", r, 32'h0);

    // R2 type word
    rd(9'h001, 2'd0, r); chk("R2", r, 32'd1);
    wr(9'h001, 2'd0, 32'hFFFFFFFF);
    rd(9'h001, 2'd0, r); chk("R2", r, 32'd1);

    for (int i = 0; i < 12; i++) begin
      wr(VEC[i].wa, VEC[i].wc, VEC[i].wd);
      rd(VEC[i].ra, VEC[i].rc, r);
      chk(vtag(i), r, VEC[i].ex);
    end

    // R12 out-of-range words
    wr(9'h1F0, 2'd0, 32'hFFFFFFFF);
    rd(9'h1F0, 2'd0, r); chk("R12", r, 32'h0);
    rd(9'h022, 2'd0, r); chk("R12", r, 32'h0);

    // R9 shared level routing: ID 40 to CPU2
    wr(9'h082, 2'd0, 32'h0);
    wr(9'h10A, 2'd0, 32'h00000004);
    wr(9'h021, 2'd0, 32'h00000100);
    wr(9'h000, 2'd0, 32'h1);
    set_spi(8, 1'b1); chk("R9", 32'(irq), 32'h4);
    set_spi(8, 1'b0); chk("R9", 32'(irq), 32'h0);

    // R10 level held across disable
    wr(9'h000, 2'd0, 32'h0);
    set_spi(8, 1'b1); chk("R10", 32'(irq), 32'h0);
    wr(9'h000, 2'd0, 32'h1); #2 chk("R10", 32'(irq), 32'h4);
    set_spi(8, 1'b0);

    // R10 edge lost while disabled
    wr(9'h082, 2'd0, 32'h00020000);
    wr(9'h000, 2'd0, 32'h0);
    set_spi(8, 1'b1); set_spi(8, 1'b0);
    wr(9'h000, 2'd0, 32'h1); #2 chk("R10", 32'(irq), 32'h0);

    // R11 edge latch and acknowledge
    set_spi(8, 1'b1); set_spi(8, 1'b0);
    chk("R11", 32'(irq), 32'h4);
    do_ack(2'd2, 6'd40); #2 chk("R11", 32'(irq), 32'h0);

    // R11 acknowledge of a held level line
    wr(9'h082, 2'd0, 32'h0);
    set_spi(8, 1'b1);
    do_ack(2'd2, 6'd40); #2 chk("R11", 32'(irq), 32'h4);
    set_spi(8, 1'b0);

    // R8 software interrupt fan-out
    rd(9'h002, 2'd0, r); chk("R8", r, 32'h0);
    wr(9'h020, 2'd1, 32'h00000020);
    wr(9'h002, 2'd0, 32'h000A0005);
    #2 chk("R8", 32'(irq), 32'h2);
    wr(9'h020, 2'd3, 32'h00000020);
    #2 chk("R4", 32'(irq), 32'hA);
    do_ack(2'd1, 6'd5); #2 chk("R8", 32'(irq), 32'h8);
    do_ack(2'd3, 6'd5); #2 chk("R8", 32'(irq), 32'h0);

    // R9 private lines reach only their owner
    wr(9'h020, 2'd0, 32'h00100000);
    @(negedge clk); ppi[16+4] = 1'b1;
    #2 chk("R9", 32'(irq), 32'h0);
    @(negedge clk); ppi[4] = 1'b1;
    #2 chk("R9", 32'(irq), 32'h1);
    @(negedge clk); ppi = '0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule